// File: doc/BRIEF.md
# Nonvolatile Shadow Memory Store Controller

This block models a byte-wide memory in which each volatile location has a nonvolatile twin. Normal traffic goes through a synchronous SRAM-style port with active-low chip enable, write enable and output enable. A snapshot of the whole volatile array into the shadow array, called a store, can be started in three ways:

- a falling edge on an active-low hardware-store pin;
- a rising edge on a power-fail bit;
- six reads at a fixed, parameterised list of addresses, made in order.

A recall copies the shadow array back into the volatile array. One recall runs automatically after every reset.

Each store or recall holds the active-low busy output low for `BUSY_CYC` cycles. During that time the port accepts no reads and no writes. The copy itself happens on the last cycle of the interval. Stores from the pin and from power-fail only run when the array has been written since the last store or recall. A store from the address sequence always runs. A saturating counter of completed stores serves as a wear indicator.

Top module: `nvs_shadow_mem`

## Requirements
- R1: When the block is idle and `ce_n`=0, `oe_n`=0, `we_n`=1 at a clock edge, `rd_en` is 1 after that edge and `rdata` holds the byte at `addr`. When the address changes on every cycle, each cycle returns the byte at that cycle's address.
- R2: When the block is idle and `ce_n`=0, `we_n`=0 at a clock edge, `wdata` is written to `addr`. After any edge where `we_n`=0, `rd_en` is 0 and `rdata` is 0, even if `oe_n` is low.
- R3: While `busy_n` is 0, writes are discarded and reads return `rd_en`=0.
- R4: In the idle state, a falling edge of `hs_n` starts a store when the array has been written since the last store or recall. `busy_n` goes low on the edge that sees the fall and stays low for exactly `BUSY_CYC` cycles.
- R5: In the idle state, a falling edge of `hs_n` or a rising edge of `pfail` starts nothing when no write has occurred since the last store or recall.
- R6: In the idle state, a rising edge of `pfail` starts a store when the array has been written since the last store or recall.
- R7: Six idle reads that hit `SW_SEQ` step 0 to step 5 in order start a store even when no write has occurred. Step i sits at bits [i*ADDR_W +: ADDR_W] of `SW_SEQ`. `busy_n` falls one cycle after the edge of the sixth read.
- R8: A read at an address other than the expected step cancels the sequence in progress. If that address equals step 0, it counts as a new step 0.
- R9: Reset starts a recall: `busy_n` is low in the first cycle after reset and stays low for `BUSY_CYC` cycles. After that, the volatile array holds the contents saved by the most recent store.
- R10: Completing a store or a recall clears the written-since flag.
- R11: `store_cnt` resets to 0, rises by 1 at each completed store, saturates at `STORE_LIMIT`, and does not change on a recall.
- R12: Triggers that arrive while `busy_n` is low are dropped. They do not start a store later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, zero when no read |
| rd_en | output | 1 | Read data valid, the stand-in for output drive |
| hs_n | input | 1 | Hardware store request, falling edge |
| pfail | input | 1 | Power-fail indication, rising edge |
| busy_n | output | 1 | Low while a store or recall runs |
| store_cnt | output | $clog2(STORE_LIMIT+1) | Saturating count of completed stores |

## Verification
The shadow array cannot be read directly. The only way to see what a store saved is to change the volatile copy after the store, apply reset, and let the automatic recall bring the saved byte back. The bench does this at the end of the run.

Dropped triggers and conditional triggers leave no trace of their own. The bench therefore sends them in a known clean or dirty state and then checks that `busy_n` stays high over a window and that `store_cnt` does not move. The limit of the wear counter is set small on the bench instance so that saturation is reached in a few stores.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    NVS_IDLE   = 2'd0,
    NVS_STORE  = 2'd1,
    NVS_RECALL = 2'd2
  } nvs_state_e;
endpackage

// File: rtl/nvs_seq_match.sv
module nvs_seq_match #(
  parameter int ADDR_W  = 9,
  parameter int SEQ_LEN = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SEQ = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic [ADDR_W-1:0] addr,
  output logic              go
);
  localparam int IDX_W = $clog2(SEQ_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(SEQ_LEN - 1);

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] want;
  logic [ADDR_W-1:0] first;

  assign want  = SEQ[int'(idx)*ADDR_W +: ADDR_W];
  assign first = SEQ[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      go  <= 1'b0;
    end else begin
      go <= 1'b0;
      if (rd_fire) begin
        if (addr == want) begin
          if (idx == LAST) begin
            idx <= '0;
            go  <= 1'b1;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end else begin
          idx <= (addr == first) ? IDX_W'(1) : '0;
        end
      end
    end
  end
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int BUSY_CYC    = 8,
  parameter int STORE_LIMIT = 1000000,
  localparam int CNT_W      = $clog2(STORE_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_n,
  input  logic             pfail,
  input  logic             sw_go,
  input  logic             wr_fire,
  output logic             busy,
  output logic             do_store,
  output logic             do_recall,
  output logic [CNT_W-1:0] store_cnt
);
  localparam int TMR_W = $clog2(BUSY_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(BUSY_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(STORE_LIMIT);

  nvs_state_e       state;
  logic [TMR_W-1:0] tmr;
  logic             dirty;
  logic             hs_q;
  logic             pf_q;
  logic             edge_req;

  assign edge_req  = (hs_q & ~hs_n) | (~pf_q & pfail);
  assign busy      = (state != NVS_IDLE);
  assign do_store  = (state == NVS_STORE)  && (tmr == '0);
  assign do_recall = (state == NVS_RECALL) && (tmr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b1;
      pf_q <= 1'b0;
    end else begin
      hs_q <= hs_n;
      pf_q <= pfail;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= NVS_RECALL;
      tmr       <= TMR_LOAD;
      dirty     <= 1'b0;
      store_cnt <= '0;
    end else begin
      case (state)
        NVS_IDLE: begin
          if (wr_fire) dirty <= 1'b1;
          if (sw_go || (edge_req && dirty)) begin
            state <= NVS_STORE;
            tmr   <= TMR_LOAD;
          end
        end
        default: begin
          if (tmr == '0) begin
            state <= NVS_IDLE;
            dirty <= 1'b0;
            if (state == NVS_STORE && store_cnt != CNT_MAX)
              store_cnt <= store_cnt + CNT_W'(1);
          end else begin
            tmr <= tmr - TMR_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_fire,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              do_store,
  input  logic              do_recall,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] vol [DEPTH];
  logic [DATA_W-1:0] shd [DEPTH];

  always_ff @(posedge clk) begin
    if (do_recall) begin
      for (int i = 0; i < DEPTH; i++) vol[i] <= shd[i];
    end else if (wr_fire) begin
      vol[addr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (do_store) begin
      for (int i = 0; i < DEPTH; i++) shd[i] <= vol[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      rd_en <= 1'b0;
    end else begin
      rd_en <= rd_fire;
      rdata <= rd_fire ? vol[addr] : '0;
    end
  end
endmodule

// File: rtl/nvs_shadow_mem.sv
module nvs_shadow_mem #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int BUSY_CYC    = 8,
  parameter int STORE_LIMIT = 1000000,
  parameter int SEQ_LEN     = 6,
  parameter logic [SEQ_LEN*ADDR_W-1:0] SW_SEQ = {
    ADDR_W'(32'h150), ADDR_W'(32'h07A), ADDR_W'(32'h13D),
    ADDR_W'(32'h0AB), ADDR_W'(32'h1C1), ADDR_W'(32'h0E3)}
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               ce_n,
  input  logic                               we_n,
  input  logic                               oe_n,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic                               rd_en,
  input  logic                               hs_n,
  input  logic                               pfail,
  output logic                               busy_n,
  output logic [$clog2(STORE_LIMIT+1)-1:0]   store_cnt
);
  logic busy, rd_fire, wr_fire, sw_go, do_store, do_recall;

  assign rd_fire = ~busy & ~ce_n & ~oe_n & we_n;
  assign wr_fire = ~busy & ~ce_n & ~we_n;
  assign busy_n  = ~busy;

  nvs_seq_match #(.ADDR_W(ADDR_W), .SEQ_LEN(SEQ_LEN), .SEQ(SW_SEQ)) u_match (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .addr(addr), .go(sw_go)
  );

  nvs_ctrl #(.BUSY_CYC(BUSY_CYC), .STORE_LIMIT(STORE_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .hs_n(hs_n), .pfail(pfail), .sw_go(sw_go),
    .wr_fire(wr_fire), .busy(busy), .do_store(do_store),
    .do_recall(do_recall), .store_cnt(store_cnt)
  );

  nvs_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst(rst), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .addr(addr), .wdata(wdata), .do_store(do_store),
    .do_recall(do_recall), .rdata(rdata), .rd_en(rd_en)
  );
endmodule

// File: rtl/nvs_shadow_mem_chk.sv
module nvs_shadow_mem_chk #(
  parameter int BUSY_CYC    = 8,
  parameter int STORE_LIMIT = 1000000,
  localparam int CNT_W      = $clog2(STORE_LIMIT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             we_n,
  input logic             busy_n,
  input logic             rd_en,
  input logic [CNT_W-1:0] store_cnt
);
  logic [15:0] low_len;

  always_ff @(posedge clk) begin
    if (rst) low_len <= '0;
    else if (!busy_n) low_len <= (low_len == 16'hFFFF) ? low_len : low_len + 16'd1;
    else low_len <= '0;
  end

  assert_busy_blocks_read_R3: assert property (@(posedge clk) disable iff (rst)
    !busy_n |=> !rd_en);

  assert_write_kills_read_R2: assert property (@(posedge clk) disable iff (rst)
    !we_n |=> !rd_en);

  assert_cnt_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    store_cnt <= CNT_W'(STORE_LIMIT));

  assert_cnt_steps_at_end_R11: assert property (@(posedge clk) disable iff (rst)
    (store_cnt != $past(store_cnt)) |->
      ((store_cnt == $past(store_cnt) + CNT_W'(1)) && $rose(busy_n)));

  assert_busy_length_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_n) |-> (low_len == 16'(BUSY_CYC)));

  assert_recall_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !busy_n);
endmodule

bind nvs_shadow_mem nvs_shadow_mem_chk #(
  .BUSY_CYC(BUSY_CYC), .STORE_LIMIT(STORE_LIMIT)
) u_chk (
  .clk(clk), .rst(rst), .we_n(we_n), .busy_n(busy_n),
  .rd_en(rd_en), .store_cnt(store_cnt)
);

// File: tb/nvs_shadow_mem_bench.sv
module nvs_shadow_mem_bench;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 8;
  localparam int BC     = 4;
  localparam int LIM    = 6;
  localparam int CNT_W  = $clog2(LIM + 1);
  localparam logic [ADDR_W-1:0] SQ [6] = '{9'h0E3, 9'h1C1, 9'h0AB, 9'h13D, 9'h07A, 9'h150};

  logic clk = 1'b0, rst = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, hs_n = 1'b1, pfail = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic rd_en, busy_n;
  logic [CNT_W-1:0] store_cnt;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  nvs_shadow_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUSY_CYC(BC), .STORE_LIMIT(LIM)) u_nvs_shadow_mem (
    .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_en(rd_en), .hs_n(hs_n), .pfail(pfail),
    .busy_n(busy_n), .store_cnt(store_cnt)
  );

  // op 1 = write, op 2 = read (data field is the expected byte)
  localparam logic [18:0] VEC [10] = '{
    {2'd1, 9'h010, 8'hA5}, {2'd1, 9'h011, 8'h3C}, {2'd1, 9'h1FF, 8'h7E},
    {2'd1, 9'h000, 8'h01}, {2'd2, 9'h011, 8'h3C}, {2'd2, 9'h010, 8'hA5},
    {2'd2, 9'h000, 8'h01}, {2'd2, 9'h1FF, 8'h7E}, {2'd1, 9'h011, 8'hC3},
    {2'd2, 9'h011, 8'hC3}};

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_port();
    ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    tick(); idle_port();
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d, output logic v);
    ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; addr = a;
    tick(); d = rdata; v = rd_en; idle_port();
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (!busy_n && n < 100) begin tick(); n++; end
  endtask

  task automatic quiet(input string req, input int cycles);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin tick(); if (!busy_n) lows++; end
    chk(req, lows, 0);
  endtask

  task automatic sw_seq();
    logic [DATA_W-1:0] d; logic v;
    for (int i = 0; i < 6; i++) rd(SQ[i], d, v);
  endtask

  task automatic do_reset();
    int n;
    rst = 1'b1; tick(); tick(); tick(); rst = 1'b0;
    chk("R9 busy after reset", busy_n, 0);
    chk("R11 count reset", store_cnt, 0);
    wait_idle(n);
    chk("R9 recall length", n, BC);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [DATA_W-1:0] d; logic v; int n;
    do_reset();
    chk("R1 no read after reset", rd_en, 0);

    // table walk: R1 reads following address each cycle, R2 writes
    foreach (VEC[k]) begin
      ce_n = 1'b0; addr = VEC[k][16:8];
      if (VEC[k][18:17] == 2'd1) begin
        we_n = 1'b0; oe_n = 1'b1; wdata = VEC[k][7:0];
      end else begin
        we_n = 1'b1; oe_n = 1'b0;
      end
      tick();
      if (VEC[k][18:17] == 2'd1) chk("R2 no read during write", {rd_en, rdata}, 0);
      else chk("R1 read data", {rd_en, rdata}, {1'b1, VEC[k][7:0]});
    end
    idle_port();

    // R2: write with output enable also low
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0; addr = 9'h040; wdata = 8'h42;
    tick(); idle_port();
    chk("R2 we low blocks output", {rd_en, rdata}, 0);
    rd(9'h040, d, v);
    chk("R2 write landed", {v, d}, {1'b1, 8'h42});

    // R4: hardware store with dirty array; R3 blocked access during busy
    wr(9'h020, 8'h11);
    hs_n = 1'b0; tick(); hs_n = 1'b1;
    chk("R4 busy starts", busy_n, 0);
    wr(9'h020, 8'h66);
    rd(9'h020, d, v);
    chk("R3 read blocked", v, 0);
    wait_idle(n);
    chk("R4 busy length", n + 2, BC);
    chk("R11 count one", store_cnt, 1);
    rd(9'h020, d, v);
    chk("R3 write discarded", {v, d}, {1'b1, 8'h11});

    // R5/R10: clean triggers skipped
    hs_n = 1'b0; tick(); hs_n = 1'b1;
    quiet("R5 R10 clean hs skipped", 6);
    pfail = 1'b1; tick();
    quiet("R5 clean pfail skipped", 6);
    pfail = 1'b0; tick();

    // R6: power-fail store when dirty
    wr(9'h041, 8'h77);
    pfail = 1'b1; tick();
    chk("R6 pfail store", busy_n, 0);
    wait_idle(n); pfail = 1'b0;
    chk("R6 count", store_cnt, 2);

    // R7: software sequence on a clean array
    sw_seq();
    chk("R7 busy one cycle later", busy_n, 1);
    tick();
    chk("R7 sequence store", busy_n, 0);
    wait_idle(n);
    chk("R7 count", store_cnt, 3);

    // R8: broken sequence then restart on step 0
    rd(SQ[0], d, v); rd(SQ[1], d, v); rd(SQ[2], d, v); rd(9'h055, d, v);
    rd(SQ[3], d, v); rd(SQ[4], d, v); rd(SQ[5], d, v);
    quiet("R8 broken sequence", 4);
    chk("R8 count held", store_cnt, 3);
    rd(SQ[0], d, v); rd(SQ[1], d, v);
    for (int i = 0; i < 6; i++) rd(SQ[i], d, v);
    tick();
    chk("R8 restart store", busy_n, 0);
    wait_idle(n);
    chk("R8 count", store_cnt, 4);

    // R12: triggers during busy are dropped
    wr(9'h042, 8'h01);
    hs_n = 1'b0; tick(); hs_n = 1'b1;
    pfail = 1'b1; tick();
    hs_n = 1'b0; tick(); hs_n = 1'b1;
    wait_idle(n);
    quiet("R12 no second store", 8);
    chk("R12 count", store_cnt, 5);
    pfail = 1'b0; tick();

    // R11 saturation
    sw_seq(); tick(); wait_idle(n);
    chk("R11 reach limit", store_cnt, LIM);
    sw_seq(); tick();
    chk("R11 store still runs", busy_n, 0);
    wait_idle(n);
    chk("R11 saturated", store_cnt, LIM);

    // R9: recall restores last stored contents
    wr(9'h020, 8'h99);
    rd(9'h020, d, v);
    chk("R9 volatile changed", d, 8'h99);
    do_reset();
    rd(9'h020, d, v);
    chk("R9 recalled byte", {v, d}, {1'b1, 8'h11});
    rd(9'h040, d, v);
    chk("R9 recalled byte 2", d, 8'h42);
    hs_n = 1'b0; tick(); hs_n = 1'b1;
    quiet("R10 clean after recall", 6);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule